// File: doc/BRIEF.md
# Contention-Resolved Bit-Plane Crossbar

This block is one bit slice of a processor-to-memory crossbar. Four processor ports can each reach any of sixteen memory lines. A processor first places a routing address on its port while its mode strobe is high. It then pulls the strobe low to claim that line, and holds the strobe low for as long as it keeps the connection. Wider buses are built by placing several planes side by side, outside this block.

There is no arbiter. A free line is granted to every processor that claims it in the same cycle. Writers that share a line are merged as a logical OR. Each writer compares the merged value with its own bit and sees a collision flag when the two differ, so the processors can back off and try again. A processor that claims a line already held by another gets a locked-out flag instead of a connection. Several readers may share one line, so a single memory value reaches all of them. Tri-state memory pins appear as separate input, output and output-enable vectors.

Top module: `xbar_plane`

## Requirements
- R1: After reset, no processor holds a line. Every `mem_oe_o`, `mem_out_o`, `dout_o`, `clash_o` and `blocked_o` bit is 0.
- R2: The port's routing address (`route_i` bits [4p+3:4p] for port p) is captured on each clock edge while `mode_i[p]` is 1. Changes to it while `mode_i[p]` is 0 do not move an existing claim or connection.
- R3: If `mode_i[p]` is 0, port p is neither connected nor locked, and no other port holds its addressed line, then port p is connected from the next edge.
- R4: If `mode_i[p]` is 0 and the addressed line is already held by another connected port, port p becomes locked out: `blocked_o[p]`=1 from the next edge, and it stays so while the strobe stays low. A locked port never drives or reads the line.
- R5: A port whose `mode_i` is 1 uses no line: its effect on the line stops in the same cycle. Its connection and its lock flag are cleared at the next edge.
- R6: `mem_out_o[m]` is the OR of `din_i` over the connected ports that are writing (`rw_i`=0) on line m, whenever `mem_oe_o[m]` is 1.
- R7: `mem_oe_o[m]` is 1 when line m has at least one connected active port, unless `phase_i` is 1 and at least one of those ports is reading (`rw_i`=1). With `phase_i`=0 a selected line is always driven.
- R8: A connected reading port sees `dout_o[p]` = `mem_in_i[m]` of its line while `phase_i` is 1. Several readers of one line all receive the same value.
- R9: A connected writing port sees `dout_o[p]` equal to the merged line value while `phase_i` is 1. `clash_o[p]`=1 whenever its `din_i` differs from the merged line value.
- R10: A line that no connected active port selects has `mem_oe_o`=0 and `mem_out_o`=0.
- R11: Two or more ports that claim the same free line in the same cycle are all connected.
- R12: `dout_o[p]` is 0 while `phase_i` is 0, and also whenever port p is not connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | 1 | Phase level: high turns read lines inward and presents data |
| mode_i | input | 4 | Per port: 1 = address phase (no claim), 0 = claim and data phase |
| rw_i | input | 4 | Per port: 1 = read, 0 = write |
| din_i | input | 4 | Per-port write bit |
| route_i | input | 16 | Four 4-bit routing addresses, port p at bits [4p+3:4p] |
| dout_o | output | 4 | Per-port data returned to the processor |
| clash_o | output | 4 | Per-port collision flag |
| blocked_o | output | 4 | Per-port locked-out flag |
| mem_in_i | input | 16 | Value present on each memory pin |
| mem_out_o | output | 16 | Value driven onto each memory pin |
| mem_oe_o | output | 16 | Drive enable of each memory pin |

## Verification
The assertions check on every cycle that a port is never both connected and locked, and that a low strobe always ends in one of the two states. They also check that strobe-high releases the port, that a lock persists while the strobe stays low, that the latched route is frozen during the data phase, and that returned data is silent in the low phase. Whether the merged line value, the enables and the collision flags are correct for a given mix of writers and readers depends on the traffic. Those results are compared each cycle against a bench model under random traffic crowded onto a few lines. Directed cases cover simultaneous claims, lock-out, route changes during the data phase and release.

// File: rtl/xbar_plane.sv
module xbar_plane #(
  parameter int NPROC = 4,
  parameter int NMEM  = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              phase_i,
  input  logic [NPROC-1:0]                  mode_i,
  input  logic [NPROC-1:0]                  rw_i,
  input  logic [NPROC-1:0]                  din_i,
  input  logic [NPROC*$clog2(NMEM)-1:0]     route_i,
  output logic [NPROC-1:0]                  dout_o,
  output logic [NPROC-1:0]                  clash_o,
  output logic [NPROC-1:0]                  blocked_o,
  input  logic [NMEM-1:0]                   mem_in_i,
  output logic [NMEM-1:0]                   mem_out_o,
  output logic [NMEM-1:0]                   mem_oe_o
);
  localparam int AW = $clog2(NMEM);

  logic [NPROC-1:0][AW-1:0] addr_q;
  logic [NPROC-1:0]         conn_q, lock_q, active;
  logic [NMEM-1:0]          busy, wr_or, rd_any, sel;

  assign active = conn_q & ~mode_i;

  always_comb begin
    busy   = '0;
    wr_or  = '0;
    rd_any = '0;
    sel    = '0;
    for (int m = 0; m < NMEM; m++) begin
      for (int p = 0; p < NPROC; p++) begin
        if (addr_q[p] == AW'(m)) begin
          if (conn_q[p]) busy[m] = 1'b1;
          if (active[p]) begin
            sel[m] = 1'b1;
            if (rw_i[p]) rd_any[m] = 1'b1;
            else         wr_or[m]  = wr_or[m] | din_i[p];
          end
        end
      end
    end
  end

  assign mem_oe_o  = sel & ~({NMEM{phase_i}} & rd_any);
  assign mem_out_o = wr_or & mem_oe_o;

  for (genvar p = 0; p < NPROC; p++) begin : g_port
    logic line_val;
    assign line_val     = rw_i[p] ? mem_in_i[addr_q[p]] : wr_or[addr_q[p]];
    assign dout_o[p]    = active[p] & phase_i & line_val;
    assign clash_o[p]   = active[p] & ~rw_i[p] & (din_i[p] != wr_or[addr_q[p]]);
    assign blocked_o[p] = lock_q[p];

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        addr_q[p] <= '0;
        conn_q[p] <= 1'b0;
        lock_q[p] <= 1'b0;
      end else if (mode_i[p]) begin
        addr_q[p] <= route_i[p*AW +: AW];
        conn_q[p] <= 1'b0;
        lock_q[p] <= 1'b0;
      end else if (!conn_q[p] && !lock_q[p]) begin
        if (busy[addr_q[p]]) lock_q[p] <= 1'b1;
        else                 conn_q[p] <= 1'b1;
      end
    end
  end
endmodule

module xbar_plane_chk #(
  parameter int NPROC = 4,
  parameter int NMEM  = 16
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  phase_i,
  input logic [NPROC-1:0]                      mode_i,
  input logic [NPROC-1:0]                      dout_o,
  input logic [NPROC-1:0]                      blocked_o,
  input logic [NPROC-1:0]                      conn_q,
  input logic [NPROC-1:0]                      lock_q,
  input logic [NPROC-1:0][$clog2(NMEM)-1:0]    addr_q
);
  for (genvar p = 0; p < NPROC; p++) begin : g_chk
    AST_CONN_LOCK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(conn_q[p] && lock_q[p])); // R4
    AST_CLAIM_RESOLVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i[p] && !conn_q[p] && !lock_q[p]) |=> (conn_q[p] || lock_q[p])); // R3
    AST_STROBE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i[p] |=> (!conn_q[p] && !blocked_o[p])); // R5
    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blocked_o[p] && !mode_i[p]) |=> blocked_o[p]); // R4
    AST_ROUTE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_i[p] |=> $stable(addr_q[p])); // R2
  end
  AST_DOUT_QUIET_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i |-> (dout_o == '0)); // R12
endmodule

bind xbar_plane xbar_plane_chk #(.NPROC(NPROC), .NMEM(NMEM)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase_i), .mode_i(mode_i),
  .dout_o(dout_o), .blocked_o(blocked_o), .conn_q(conn_q), .lock_q(lock_q),
  .addr_q(addr_q));

// File: tb/xbar_plane_tb.sv
module xbar_plane_tb_top;
  localparam int NP = 4, NM = 16, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0, phase = 1'b0;
  logic [NP-1:0] mode = '1, rw = '0, din = '0;
  logic [NP*AW-1:0] route = '0;
  logic [NM-1:0] mem_in = '0;
  logic [NP-1:0] dout, clash, blocked;
  logic [NM-1:0] mem_out, mem_oe;

  int errors = 0, checks = 0;
  logic [NP-1:0] m_conn = '0, m_lock = '0;
  logic [AW-1:0] m_addr [NP];

  always #4 clk = ~clk;

  xbar_plane #(.NPROC(NP), .NMEM(NM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .mode_i(mode), .rw_i(rw),
    .din_i(din), .route_i(route), .dout_o(dout), .clash_o(clash),
    .blocked_o(blocked), .mem_in_i(mem_in), .mem_out_o(mem_out), .mem_oe_o(mem_oe));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [NM-1:0] e_or, e_rd, e_sel, e_oe;
    logic [NP-1:0] e_dout, e_clash, act;
    e_or = '0; e_rd = '0; e_sel = '0;
    for (int p = 0; p < NP; p++) begin
      act[p] = m_conn[p] && !mode[p];
      if (act[p]) begin
        e_sel[m_addr[p]] = 1'b1;
        if (rw[p]) e_rd[m_addr[p]] = 1'b1;
        else if (din[p]) e_or[m_addr[p]] = 1'b1;
      end
    end
    e_oe = e_sel & ~(phase ? e_rd : '0);
    for (int p = 0; p < NP; p++) begin
      e_dout[p]  = act[p] && phase && (rw[p] ? mem_in[m_addr[p]] : e_or[m_addr[p]]);
      e_clash[p] = act[p] && !rw[p] && (din[p] != e_or[m_addr[p]]);
    end
    chk("R7/R10 mem_oe", 32'(mem_oe), 32'(e_oe));
    chk("R6/R10 mem_out", 32'(mem_out), 32'(e_or & e_oe));
    chk("R8/R9/R12 dout", 32'(dout), 32'(e_dout));
    chk("R9 clash", 32'(clash), 32'(e_clash));
    chk("R4/R5 blocked", 32'(blocked), 32'(m_lock));
  endtask

  task automatic model_edge();
    logic [NM-1:0] bz;
    bz = '0;
    for (int p = 0; p < NP; p++) if (m_conn[p]) bz[m_addr[p]] = 1'b1;
    for (int p = 0; p < NP; p++) begin
      if (!rst_n) begin m_conn[p] = 0; m_lock[p] = 0; m_addr[p] = '0; end
      else if (mode[p]) begin
        m_addr[p] = route[p*AW +: AW]; m_conn[p] = 0; m_lock[p] = 0;
      end else if (!m_conn[p] && !m_lock[p]) begin
        if (bz[m_addr[p]]) m_lock[p] = 1; else m_conn[p] = 1;
      end
    end
  endtask

  task automatic step();
    #1 compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic set_route(int p, int a);
    route[p*AW +: AW] = AW'(a);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) begin @(posedge clk); model_edge(); end
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 mem_oe", 32'(mem_oe), 0);
    chk("R1 dout/clash/blocked", {dout, clash, blocked}, 0);
    phase = 1'b1;
    // R11: P0 and P1 claim line 5 together
    set_route(0, 5); set_route(1, 5); set_route(2, 5); set_route(3, 9);
    step();
    mode = 4'b1100; rw = 4'b0000; din = 4'b0001;
    step(); step();
    chk("R11 both connected, no lock", 32'(blocked), 0);
    chk("R6 merged write on line 5", 32'(mem_out[5]), 1);
    chk("R9 clash on P1 only", 32'(clash), 32'b0010);
    // R4: P2 claims held line 5 -> locked, no effect on line
    mode = 4'b1000; din = 4'b0101;
    step(); step();
    chk("R4 P2 locked", 32'(blocked), 32'b0100);
    chk("R4 locked port does not drive", 32'(clash[2]), 0);
    // R2: route change during data phase ignored
    set_route(0, 12);
    step();
    chk("R2 P0 still on line 5", 32'(mem_oe[5]), 1);
    chk("R10 line 12 idle", 32'(mem_oe[12]), 0);
    // R8: P0,P1 read line 5 as broadcast
    rw = 4'b0011; mem_in = 16'h0020;
    #1 chk("R8 broadcast read", 32'(dout[1:0]), 32'b11);
    chk("R7 read line turned inward", 32'(mem_oe[5]), 0);
    phase = 1'b0;
    #1 chk("R12 dout quiet in low phase", 32'(dout), 0);
    chk("R7 driven in low phase", 32'(mem_oe[5]), 1);
    step();
    phase = 1'b1;
    // R5: release all, line free and lock cleared
    mode = 4'b1111;
    #1 chk("R5 line dropped same cycle", 32'(mem_oe), 0);
    step();
    chk("R5 lock cleared", 32'(blocked), 0);
    // R3: P3 alone claims line 9
    mode = 4'b0111; rw = 4'b0000; din = 4'b1000;
    step(); step();
    chk("R3 P3 drives line 9", 32'(mem_out[9]), 1);
    mode = 4'b1111;
    step();
    // random traffic crowded on few lines
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 5) == 0) mode[p] = ~mode[p];
        set_route(p, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 2));
        rw[p]  = $urandom_range(0, 2) == 0;
        din[p] = $urandom_range(0, 1);
      end
      phase  = $urandom_range(0, 1);
      mem_in = 16'($urandom);
      if ($urandom_range(0, 199) == 0) rst_n = 1'b0; else rst_n = 1'b1;
      step();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule